// File: doc/BRIEF.md
# Effective Address Range Checker

This block forms an effective address from a direct address and, when indexing is selected, an index value. It then classifies the result against two limits. The first limit is the number of memory locations actually installed, which need not be a power of two. The second limit is the range that the active address bits can hold. A start strobe launches one evaluation, and the registered result appears one clock later together with a done pulse.

There are three possible outcomes:

- **In range.** An address at or below the highest installed location passes through untouched.
- **Beyond the register range.** A sum too large for the register range is folded back modulo two to the power of the active width, silently.
- **Between the two limits.** An address above the installed memory but inside the register range is a fault. With storage protection on, a fault sets a sticky violation flag, aborts the instruction and requests an internal interrupt. With protection off, a fault requests a processor stop.

Top module: `ea_range_check`

## Requirements
- R1: When `idx_en` is 1 the candidate address is `base + index`; when `idx_en` is 0 the candidate is `base` alone and `index` has no effect.
- R2: A candidate of 2^AW or more is reduced modulo 2^AW onto `ea`. In this case `stop_req`, `abort` and `irq` stay 0 and `viol_flag` is not set.
- R3: With AW = 16, base 48000 indexed by 27000 yields `ea` = 9464.
- R4: `mem_size` gives the number of installed locations (1 to 2^AW, AW+1 bits wide), so the highest valid address is `mem_size`-1. A candidate below 2^AW and below `mem_size` appears unchanged on `ea` and raises no fault output.
- R5: A candidate at or above `mem_size` but below 2^AW, with `prot_en` = 1, sets `viol_flag` and pulses `abort` and `irq` for one cycle, with `stop_req` at 0.
- R6: The same out-of-memory condition with `prot_en` = 0 pulses `stop_req` for one cycle and leaves `abort`, `irq` and `viol_flag` unchanged at 0.
- R7: Results are registered. `ea`, `done` and the fault pulses change on the clock edge that samples `start`. `done` is high only in the cycle after a start, and `ea` holds between starts.
- R8: `viol_flag` stays set until `viol_clr` is sampled high. A set caused by a start in the same cycle as `viol_clr` wins over the clear.
- R9: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one evaluation |
| base | input | AW | Direct address from the instruction |
| index | input | AW | Index register contents |
| idx_en | input | 1 | Add index to base |
| mem_size | input | AW+1 | Number of installed locations |
| prot_en | input | 1 | Storage protection active |
| viol_clr | input | 1 | Clear the violation flag |
| ea | output | AW | Effective address |
| done | output | 1 | Result valid pulse |
| stop_req | output | 1 | Processor stop request pulse |
| abort | output | 1 | Instruction abort pulse |
| irq | output | 1 | Internal interrupt request pulse |
| viol_flag | output | 1 | Sticky address violation indicator |

## Verification
A protected out-of-memory evaluation and a flag clear can arrive in the same cycle. One function sets the violation flag and the other clears it. The bench presents `start` with a faulting address at the same time as `viol_clr`, and expects the flag to read 1 afterwards. It then confirms that a lone clear drops the flag. Around this check, a full sweep over a 4-bit configuration covers every base, index, enable, protection setting and four memory sizes, and judges each result against arithmetic done in the bench.

// File: rtl/ea_range_check.sv
module ea_range_check #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic          idx_en,
  input  logic [AW:0]   mem_size,
  input  logic          prot_en,
  input  logic          viol_clr,
  output logic [AW-1:0] ea,
  output logic          done,
  output logic          stop_req,
  output logic          abort,
  output logic          irq,
  output logic          viol_flag
);

  logic [AW:0] cand;
  logic        wrap;
  logic        oom;

  assign cand = {1'b0, base} + {1'b0, (idx_en ? index : {AW{1'b0}})};
  assign wrap = cand[AW];
  assign oom  = !wrap && (cand >= mem_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea       <= '0;
      done     <= 1'b0;
      stop_req <= 1'b0;
      abort    <= 1'b0;
      irq      <= 1'b0;
    end else begin
      done     <= start;
      stop_req <= start && oom && !prot_en;
      abort    <= start && oom && prot_en;
      irq      <= start && oom && prot_en;
      if (start) ea <= cand[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      viol_flag <= 1'b0;
    else if (start && oom && prot_en) viol_flag <= 1'b1;
    else if (viol_clr)               viol_flag <= 1'b0;
  end

endmodule

module ea_range_check_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] base,
  input logic [AW-1:0] index,
  input logic          idx_en,
  input logic          prot_en,
  input logic          viol_clr,
  input logic          done,
  input logic          stop_req,
  input logic          abort,
  input logic          irq,
  input logic          viol_flag
);

  logic [AW:0] raw_sum;
  assign raw_sum = {1'b0, base} + {1'b0, index};

  a_r7_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  a_r7_pulses_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req || abort || irq) |-> done);

  a_r2_wrap_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idx_en && raw_sum[AW]) |=> (!stop_req && !abort && !irq));

  a_r5_abort_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (viol_flag && irq && !stop_req));

  a_r6_stop_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> ($past(!prot_en) && !abort));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clr) |=> viol_flag);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_clr && !start) |=> !viol_flag);

endmodule

bind ea_range_check ea_range_check_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .base(base), .index(index),
  .idx_en(idx_en), .prot_en(prot_en), .viol_clr(viol_clr), .done(done),
  .stop_req(stop_req), .abort(abort), .irq(irq), .viol_flag(viol_flag)
);

// File: tb/ea_range_check_tb.sv
`timescale 1ns/1ps
module ea_range_check_tb;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start = 0, idx_en = 0, prot_en = 0, viol_clr = 0;
  logic [AW-1:0] base = '0, index = '0;
  logic [AW:0]   mem_size = 5'd16;
  logic [AW-1:0] ea;
  logic          done, stop_req, abort, irq, viol_flag;

  ea_range_check #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .index(index),
    .idx_en(idx_en), .mem_size(mem_size), .prot_en(prot_en), .viol_clr(viol_clr),
    .ea(ea), .done(done), .stop_req(stop_req), .abort(abort), .irq(irq),
    .viol_flag(viol_flag)
  );

  logic        w_start = 0, w_idx = 0, w_prot = 0, w_clr = 0;
  logic [15:0] w_base = '0, w_index = '0;
  logic [16:0] w_mem = 17'd49152;
  logic [15:0] w_ea;
  logic        w_done, w_stop, w_abort, w_irq, w_flag;

  ea_range_check #(.AW(16)) u_dut_w16 (
    .clk(clk), .rst_n(rst_n), .start(w_start), .base(w_base), .index(w_index),
    .idx_en(w_idx), .mem_size(w_mem), .prot_en(w_prot), .viol_clr(w_clr),
    .ea(w_ea), .done(w_done), .stop_req(w_stop), .abort(w_abort), .irq(w_irq),
    .viol_flag(w_flag)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input int b, input int x, input bit ie, input int ms, input bit pe);
    int s, e_ea;
    bit e_oom;
    s     = b + (ie ? x : 0);
    e_ea  = s % (1 << AW);
    e_oom = (s < (1 << AW)) && (s >= ms);
    @(negedge clk);
    base = b[AW-1:0]; index = x[AW-1:0]; idx_en = ie;
    mem_size = ms[AW:0]; prot_en = pe; start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 1'b1, "R7 done", int'(done), 1);
    chk(int'(ea) == e_ea, (s >= 16) ? "R2 wrap ea" : (ie ? "R1 indexed ea" : "R1 direct ea"), int'(ea), e_ea);
    if (!e_oom) begin
      chk({stop_req, abort, irq, viol_flag} == 4'b0,
          (s >= 16) ? "R2 no fault on wrap" : "R4 no flags in range",
          int'({stop_req, abort, irq, viol_flag}), 0);
    end else if (pe) begin
      chk({stop_req, abort, irq, viol_flag} == 4'b0111, "R5 protected fault",
          int'({stop_req, abort, irq, viol_flag}), 7);
    end else begin
      chk({stop_req, abort, irq, viol_flag} == 4'b1000, "R6 unprotected stop",
          int'({stop_req, abort, irq, viol_flag}), 8);
    end
    viol_clr = 1;
    @(negedge clk);
    viol_clr = 0;
    chk(viol_flag == 1'b0, "R8 clear", int'(viol_flag), 0);
    chk({done, stop_req, abort, irq} == 4'b0, "R7 single-cycle pulses",
        int'({done, stop_req, abort, irq}), 0);
    chk(int'(ea) == e_ea, "R7 ea holds", int'(ea), e_ea);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int sizes[4] = '{16, 12, 9, 1};
    repeat (2) @(negedge clk);
    chk({ea, done, stop_req, abort, irq, viol_flag} == '0, "R9 reset state",
        int'({ea, done, stop_req, abort, irq, viol_flag}), 0);
    chk({w_ea, w_done, w_stop, w_abort, w_irq, w_flag} == '0, "R9 reset state w16",
        int'({w_ea, w_done, w_stop, w_abort, w_irq, w_flag}), 0);
    rst_n = 1;

    for (int m = 0; m < 4; m++)
      for (int pe = 0; pe < 2; pe++)
        for (int ie = 0; ie < 2; ie++)
          for (int b = 0; b < 16; b++)
            for (int x = 0; x < 16; x++)
              run_op(b, x, ie[0], sizes[m], pe[0]);

    // R8: fault sets flag, flag sticks while idle, set wins over clear
    @(negedge clk);
    base = 4'd10; index = 4'd0; idx_en = 0; mem_size = 5'd9; prot_en = 1; start = 1;
    @(negedge clk);
    start = 0;
    chk(viol_flag == 1'b1, "R8 set", int'(viol_flag), 1);
    repeat (3) @(negedge clk);
    chk(viol_flag == 1'b1, "R8 sticky", int'(viol_flag), 1);
    base = 4'd12; start = 1; viol_clr = 1;
    @(negedge clk);
    start = 0; viol_clr = 0;
    chk(viol_flag == 1'b1, "R8 set beats clear", int'(viol_flag), 1);
    chk(abort == 1'b1, "R5 abort in collision", int'(abort), 1);
    viol_clr = 1;
    @(negedge clk);
    viol_clr = 0;
    chk(viol_flag == 1'b0, "R8 lone clear", int'(viol_flag), 0);

    // R3: 16-bit wrap example and non power-of-two memory
    @(negedge clk);
    w_base = 16'd48000; w_index = 16'd27000; w_idx = 1; w_prot = 1; w_start = 1;
    @(negedge clk);
    w_start = 0;
    chk(int'(w_ea) == 9464, "R3 wrap example", int'(w_ea), 9464);
    chk({w_stop, w_abort, w_flag} == 3'b0, "R2 no fault w16",
        int'({w_stop, w_abort, w_flag}), 0);
    w_base = 16'd49000; w_index = 16'd1000; w_prot = 0; w_start = 1;
    @(negedge clk);
    w_start = 0;
    chk(int'(w_ea) == 50000 && w_stop == 1'b1, "R6 stop w16",
        int'(w_stop), 1);
    w_base = 16'd49151; w_idx = 0; w_start = 1;
    @(negedge clk);
    w_start = 0;
    chk(int'(w_ea) == 49151 && w_stop == 1'b0, "R4 top location w16",
        int'(w_ea), 49151);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule